// File: doc/BRIEF.md
# Serial Row-Rotation Unit for a 32-bit Block-Cipher Datapath

This unit performs the AES ShiftRows byte permutation on a 128-bit state that reaches it one 32-bit column per clock. It sits between the substitution stage and the column-mixing stage of a narrow cipher datapath. A sender presents a column on `in_col` and raises `in_valid` for that cycle. Idle cycles may fall between columns. The unit collects four columns in a 128-bit shift register. It then places the permuted state in an output buffer and hands the permuted columns out one per clock through a one-cycle holding register.

Every register is written only under an explicit enable. The capture register moves only when a valid column is taken. The output buffer is written once per state. The holding register is written only while a column is being delivered. No flip-flop toggles on cycles that carry no useful data. A new state may start loading in the cycle right after the last column of the previous one, and the output stream then continues without a gap.

Top module: `lowact_shiftrows`

## Requirements
- R1: While `rst_n` is low, and after reset until a state completes, `out_valid` is 0 and `out_col` is 0.
- R2: `out_valid` stays low until four columns have been accepted. The first permuted column appears on the second rising edge after the edge that accepts the fourth column.
- R3: Input columns are numbered 0 to 3 in arrival order. Byte row r of a column occupies bits [8r+7:8r]. Output column c, delivered in order c = 0, 1, 2, 3, carries in row r the row-r byte of input column (c+r) mod 4.
- R4: Each complete state yields exactly four output cycles, on consecutive clocks, with `out_valid` high.
- R5: While `in_valid` is low, `in_col` is ignored and the captured columns keep their value. Idle cycles between columns do not change the result.
- R6: When a second state follows the first with no idle cycle, `out_valid` stays high for eight consecutive cycles, and the second state's columns follow the first state's columns directly.
- R7: `out_col` changes only on cycles where `out_valid` is high. Otherwise it holds the last delivered column.
- R8: Asserting reset in the middle of a state discards the partly loaded columns. The next four columns form a fresh state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | `in_col` carries a state column this cycle |
| in_col | input | 32 | Incoming state column, row r in bits [8r+7:8r] |
| out_valid | output | 1 | `out_col` carries a permuted column this cycle |
| out_col | output | 32 | Permuted column from the holding register |

## Verification
A column counter that drifts would show at the ports as `out_valid` rising after three or five accepted columns. It would also show as rows taken from the wrong source column, and the bench sees either two cycles after the affected state completes. A wrong drain index or remaining-count value appears as a repeated or missing output column, or as a run of `out_valid` other than four (or eight when states are back to back), and shows within the following four cycles. An enable that leaks shows as a changed result after idle cycles that carry junk on `in_col`, or as `out_col` moving while `out_valid` is low.

// File: rtl/srow_pkg.sv
package srow_pkg;
  localparam int unsigned SROW_ROWS_DEF   = 4;
  localparam int unsigned SROW_BYTE_W_DEF = 8;

  // Source column that feeds row r of output column c.
  function automatic int unsigned srow_src_col(input int unsigned c,
                                               input int unsigned r,
                                               input int unsigned rows);
    return (c + r) % rows;
  endfunction
endpackage

// File: rtl/srow_capture.sv
module srow_capture
  import srow_pkg::*;
#(
  parameter int unsigned ROWS   = SROW_ROWS_DEF,
  parameter int unsigned BYTE_W = SROW_BYTE_W_DEF,
  localparam int unsigned COL_W = ROWS * BYTE_W,
  localparam int unsigned ST_W  = COL_W * ROWS,
  localparam int unsigned CNT_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [COL_W-1:0] in_col,
  output logic [ST_W-1:0]  state_next,
  output logic             state_last,
  output logic [ST_W-1:0]  cap_q,
  output logic [CNT_W-1:0] col_cnt
);
  logic [ST_W-1:0]  cap_d;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last = (cnt_q == CNT_W'(ROWS - 1));

  always_comb begin
    cap_d = cap_q;
    cnt_d = cnt_q;
    if (in_valid) begin
      cap_d = {in_col, cap_q[ST_W-1:COL_W]};
      cnt_d = at_last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else if (in_valid) begin
      cap_q <= cap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (in_valid) begin
      cnt_q <= cnt_d;
    end
  end

  assign state_next = cap_d;
  assign state_last = in_valid && at_last;
  assign col_cnt    = cnt_q;
endmodule

// File: rtl/srow_permute.sv
module srow_permute
  import srow_pkg::*;
#(
  parameter int unsigned ROWS   = SROW_ROWS_DEF,
  parameter int unsigned BYTE_W = SROW_BYTE_W_DEF,
  localparam int unsigned COL_W = ROWS * BYTE_W,
  localparam int unsigned ST_W  = COL_W * ROWS
) (
  input  logic [ST_W-1:0] st_in,
  output logic [ST_W-1:0] st_out
);
  for (genvar c = 0; c < ROWS; c++) begin : g_col
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      localparam int unsigned SRC = srow_src_col(c, r, ROWS);
      assign st_out[c*COL_W + r*BYTE_W +: BYTE_W] =
             st_in[SRC*COL_W + r*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/srow_drain.sv
module srow_drain
  import srow_pkg::*;
#(
  parameter int unsigned ROWS   = SROW_ROWS_DEF,
  parameter int unsigned BYTE_W = SROW_BYTE_W_DEF,
  localparam int unsigned COL_W = ROWS * BYTE_W,
  localparam int unsigned ST_W  = COL_W * ROWS,
  localparam int unsigned IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int unsigned REM_W = $clog2(ROWS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ST_W-1:0]  perm_state,
  output logic             out_valid,
  output logic [COL_W-1:0] out_col
);
  logic [ST_W-1:0]  buf_q;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [REM_W-1:0] rem_q, rem_d;
  logic [COL_W-1:0] hold_q, hold_d;
  logic             vld_q;
  logic             drain_go;
  logic             ctl_en;

  assign drain_go = (rem_q != '0);
  assign ctl_en   = load || drain_go;

  always_comb begin
    hold_d = buf_q[idx_q*COL_W +: COL_W];
    idx_d  = idx_q;
    rem_d  = rem_q;
    if (load) begin
      idx_d = '0;
      rem_d = REM_W'(ROWS);
    end else if (drain_go) begin
      idx_d = (idx_q == IDX_W'(ROWS - 1)) ? '0 : idx_q + 1'b1;
      rem_d = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
    end else if (load) begin
      buf_q <= perm_state;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (drain_go) begin
      hold_q <= hold_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      rem_q <= '0;
    end else if (ctl_en) begin
      idx_q <= idx_d;
      rem_q <= rem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= drain_go;
    end
  end

  assign out_valid = vld_q;
  assign out_col   = hold_q;
endmodule

// File: rtl/lowact_shiftrows.sv
module lowact_shiftrows
  import srow_pkg::*;
#(
  parameter int unsigned ROWS   = SROW_ROWS_DEF,
  parameter int unsigned BYTE_W = SROW_BYTE_W_DEF,
  localparam int unsigned COL_W = ROWS * BYTE_W,
  localparam int unsigned ST_W  = COL_W * ROWS,
  localparam int unsigned CNT_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [COL_W-1:0] in_col,
  output logic             out_valid,
  output logic [COL_W-1:0] out_col
);
  logic [ST_W-1:0]  state_next;
  logic [ST_W-1:0]  state_perm;
  logic [ST_W-1:0]  cap_q;
  logic [CNT_W-1:0] col_cnt;
  logic             state_last;

  srow_capture #(.ROWS(ROWS), .BYTE_W(BYTE_W)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_col     (in_col),
    .state_next (state_next),
    .state_last (state_last),
    .cap_q      (cap_q),
    .col_cnt    (col_cnt)
  );

  srow_permute #(.ROWS(ROWS), .BYTE_W(BYTE_W)) u_permute (
    .st_in  (state_next),
    .st_out (state_perm)
  );

  srow_drain #(.ROWS(ROWS), .BYTE_W(BYTE_W)) u_drain (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (state_last),
    .perm_state (state_perm),
    .out_valid  (out_valid),
    .out_col    (out_col)
  );
endmodule

// File: rtl/srow_chk.sv
module srow_chk #(
  parameter int unsigned ROWS   = 4,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned COL_W = ROWS * BYTE_W,
  localparam int unsigned ST_W  = COL_W * ROWS,
  localparam int unsigned CNT_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int unsigned CR_W  = $clog2(2 * ROWS + 1) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [ST_W-1:0]  cap_q,
  input logic [CNT_W-1:0] col_cnt,
  input logic             out_valid,
  input logic [COL_W-1:0] out_col
);
  // Independent port-level model: own column count and output credit.
  logic [CNT_W-1:0] seen_q;
  logic             pend_q;
  logic [CR_W-1:0]  credit_q;
  logic [CR_W-1:0]  credit_d;
  logic             seen_last;

  assign seen_last = in_valid && (seen_q == CNT_W'(ROWS - 1));

  always_comb begin
    credit_d = credit_q;
    if (pend_q)    credit_d = credit_d + CR_W'(ROWS);
    if (out_valid) credit_d = credit_d - CR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q   <= '0;
      pend_q   <= 1'b0;
      credit_q <= '0;
    end else begin
      if (in_valid) seen_q <= seen_last ? '0 : seen_q + 1'b1;
      pend_q   <= seen_last;
      credit_q <= credit_d;
    end
  end

  // R5: the capture register holds when no column is offered
  a_r5_cap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cap_q));

  // R7: the holding register moves only on delivery cycles
  a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_col) |-> out_valid);

  // R2: first output two edges after the fourth column is accepted
  a_r2_first_out: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && col_cnt == CNT_W'(ROWS - 1)) |=> ##1 out_valid);

  // R4 / R6: out_valid is high exactly while delivered columns are owed
  a_r4_credit: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (credit_q != '0));

  // R8: the design's column count agrees with the port-level count
  a_r8_count_sync: assert property (@(posedge clk) disable iff (!rst_n)
    col_cnt == seen_q);
endmodule

bind lowact_shiftrows srow_chk #(.ROWS(ROWS), .BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .cap_q     (cap_q),
  .col_cnt   (col_cnt),
  .out_valid (out_valid),
  .out_col   (out_col)
);

// File: tb/sim_lowact_shiftrows.sv
module sim_lowact_shiftrows;
  localparam int ROWS  = 4;
  localparam int COL_W = 32;
  localparam int ST_W  = 128;
  localparam int NVEC  = 5;

  // {gap cycles between columns, 128-bit state with column j in bits [32j+31:32j]}
  localparam logic [131:0] VECS [NVEC] = '{
    {4'd0, 128'h0F0E0D0C_0B0A0908_07060504_03020100},
    {4'd0, 128'h00112233_44556677_8899AABB_CCDDEEFF},
    {4'd2, 128'hDEADBEEF_01234567_89ABCDEF_FEDCBA98},
    {4'd1, 128'hFFFFFFFF_00000000_FFFFFFFF_00000000},
    {4'd3, 128'hA5A5A5A5_5A5A5A5A_C3C3C3C3_3C3C3C3C}
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid;
  logic [COL_W-1:0] in_col;
  logic             out_valid;
  logic [COL_W-1:0] out_col;

  int checks = 0;
  int fails  = 0;
  int cur_run = 0;
  int max_run = 0;
  logic [COL_W-1:0] expq [$];

  always #4 clk = ~clk;

  lowact_shiftrows u0 (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
    .in_col (in_col), .out_valid (out_valid), .out_col (out_col)
  );

  task automatic chk(input string req, input logic [COL_W-1:0] act,
                     input logic [COL_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected column from R3: row r of output column c = row r of input column (c+r)%4
  function automatic logic [COL_W-1:0] exp_col(input logic [ST_W-1:0] st, input int c);
    logic [COL_W-1:0] v;
    for (int r = 0; r < ROWS; r++)
      v[8*r +: 8] = st[32*((c + r) % ROWS) + 8*r +: 8];
    return v;
  endfunction

  task automatic push_exp(input logic [ST_W-1:0] st);
    for (int c = 0; c < ROWS; c++) expq.push_back(exp_col(st, c));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_col   = 32'hBAD0_0000 | i;
    end
  endtask

  task automatic send_state(input logic [ST_W-1:0] st, input int gap);
    push_exp(st);
    for (int j = 0; j < ROWS; j++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_col   = st[32*j +: 32];
      if (j < ROWS - 1) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          in_valid = 1'b0;
          in_col   = ~st[32*j +: 32];  // junk on idle cycles (R5)
        end
      end
    end
  endtask

  // Output monitor: content and order (R3), run length tracking (R4, R6)
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        cur_run++;
        if (expq.size() == 0) chk("R3 unexpected output", out_col, 32'hxxxxxxxx);
        else chk("R3 column content", out_col, expq.pop_front());
      end else begin
        cur_run = 0;
      end
      if (cur_run > max_run) max_run = cur_run;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [ST_W-1:0] st;
    bit seen;
    rst_n = 1'b0; in_valid = 1'b0; in_col = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset out_valid", 32'(out_valid), 32'd0);
    chk("R1 reset out_col", out_col, 32'd0);
    rst_n = 1'b1;
    idle(3);
    chk("R1 idle after reset out_valid", 32'(out_valid), 32'd0);

    // Table walk: R3 content, R5 gaps with junk
    for (int v = 0; v < NVEC; v++) begin
      send_state(VECS[v][127:0], int'(VECS[v][131:128]));
      idle(7);
    end
    chk("R3 all table columns delivered", 32'(expq.size()), 32'd0);

    // R3 literal spot values for the first table state
    st = VECS[0][127:0];
    chk("R3 literal col0", exp_col(st, 0), 32'h0F0A0500);
    chk("R3 literal col1", exp_col(st, 1), 32'h030E0904);

    // R2 timing and R4 run length
    max_run = 0;
    st = 128'h11223344_55667788_99AABBCC_DDEEFF00;
    send_state(st, 0);
    @(negedge clk); in_valid = 1'b0;
    chk("R2 no output one edge after last column", 32'(out_valid), 32'd0);
    @(negedge clk);
    chk("R2 output two edges after last column", 32'(out_valid), 32'd1);
    idle(8);
    chk("R4 single state run length", 32'(max_run), 32'd4);
    // R7: out_col keeps the last column while out_valid is low
    chk("R7 out_valid low after drain", 32'(out_valid), 32'd0);
    chk("R7 out_col holds last column", out_col, exp_col(st, 3));
    idle(3);
    chk("R7 out_col still held", out_col, exp_col(st, 3));

    // R2: three columns only, long pause, no output; fourth completes the state
    st = 128'h0BADF00D_CAFEBABE_13579BDF_2468ACE0;
    push_exp(st);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk); in_valid = 1'b1; in_col = st[32*j +: 32];
    end
    seen = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); in_valid = 1'b0; in_col = 32'hFFFF_FFFF;
      if (out_valid) seen = 1'b1;
    end
    chk("R2 no output with three columns", 32'(seen), 32'd0);
    @(negedge clk); in_valid = 1'b1; in_col = st[127:96];
    idle(8);
    chk("R5 paused state delivered", 32'(expq.size()), 32'd0);

    // R6 back-to-back states
    max_run = 0;
    send_state(128'h01010101_02020202_03030303_04040404, 0);
    send_state(128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F, 0);
    idle(10);
    chk("R6 back-to-back run length", 32'(max_run), 32'd8);
    chk("R6 back-to-back all delivered", 32'(expq.size()), 32'd0);

    // R8 reset mid-state discards partial columns
    @(negedge clk); in_valid = 1'b1; in_col = 32'hDEAD_0001;
    @(negedge clk); in_valid = 1'b1; in_col = 32'hDEAD_0002;
    @(negedge clk); in_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    chk("R1 out_valid low in reset", 32'(out_valid), 32'd0);
    chk("R1 out_col cleared in reset", out_col, 32'd0);
    rst_n = 1'b1;
    send_state(128'h76543210_FEDCBA98_31415926_27182818, 0);
    idle(8);
    chk("R8 fresh state after reset delivered", 32'(expq.size()), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule